// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block sits behind a CAN bit-stream decoder and decides where each received standard-identifier frame goes. A decoded frame arrives as an 11-bit identifier, a 4-bit data length code and 64 bits of payload, marked by a one-cycle valid strobe. In the same cycle the block tests the frame against every receive mailbox. A mailbox can take the frame only if its code field shows it as empty and armed. The frame's identifier must also equal the mailbox identifier on every bit that the active mask marks as significant.

Software controls the block through a word-wide register port. Through it, software programs the mailbox words, one mask per mailbox, a shared mask, two mode bits and the per-mailbox reception flags. A mode bit picks the mask scheme. When the bit is clear, every mailbox uses the shared mask. When it is set, each mailbox uses its own mask, so that one mailbox can cover an identifier range while its neighbour accepts a single identifier. A second mode bit drops frames that the node itself sent.

Top module: `can_rx_acceptance`

## Requirements
- R1: After reset, every mailbox word, every mask, the shared mask, the mode bits and all flags read as zero, and `mb_flags` is zero.
- R2: The port uses word addresses. A read returns in `reg_rdata` on the clock edge after the address is presented. Address 4*m+w selects word w of mailbox m: w=0 is control/status, w=1 is the identifier, w=2 holds the upper data bytes and w=3 the lower data bytes. Address 4*NUM_MB+m is the mask of mailbox m. Address 5*NUM_MB is the shared mask. Address 5*NUM_MB+1 holds the mode bits: bit 0 enables individual masks and bit 1 drops self-sent frames. Address 5*NUM_MB+2 holds the flags.
- R3: With bit 0 of the mode register clear, a mailbox whose code (bits 26:24 of word 0) is 4 accepts a frame when ((rx_id XOR id[28:18]) AND shared_mask[28:18]) is zero. A shared mask of zero accepts any identifier.
- R4: With bit 0 of the mode register set, each mailbox uses bits 28:18 of its own mask in place of the shared mask. For example, identifier 0x200 with mask 0x3F0 accepts 0x200 to 0x20F and rejects 0x210 and 0x211, while a mask of 0x3FF accepts only the exact identifier.
- R5: When several armed mailboxes match, only the lowest-numbered one receives the frame, and the others keep their contents.
- R6: A mailbox that receives a frame has its word 0 rewritten to code 2 in bits 26:24 with the DLC in bits 19:16 and all other bits zero. Its word 1 is rewritten to the received identifier in bits 28:18 with all other bits zero. Word 2 takes rx_data[63:32] and word 3 takes rx_data[31:0].
- R7: A mailbox whose code is not 4 takes no frame. Writing code 4 back re-arms it.
- R8: Storing a frame sets that mailbox's flag. The flag is visible in `mb_flags` and in the flag register after the same clock edge that stores the frame.
- R9: Writing the flag register clears exactly the flag bits written as 1 and leaves the others unchanged. When a frame store and a clearing write hit the same flag in one cycle, the flag ends up set.
- R10: A frame that matches no armed mailbox changes no mailbox word and no flag.
- R11: With bit 1 of the mode register set, a frame with `rx_self` high is dropped. With that bit clear, such a frame is filtered like any other frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe marking a decoded frame |
| rx_id | input | 11 | Received standard identifier |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received payload, first byte in bits 63:56 |
| rx_self | input | 1 | Frame was transmitted by this node |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (8 bits at defaults) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mb_flags | output | NUM_MB | Per-mailbox reception flags |

## Verification
The assertions take two things for granted. First, a flag can only rise in a cycle after `rx_valid` was high. Second, software does not write a mailbox word in the same cycle that a frame is stored into that mailbox. The W1C property is only checked in cycles without a frame, because a same-cycle store may legitimately set a flag again. The stimulus keeps every mailbox write in a cycle apart from every frame. The only overlap it creates on purpose is a frame together with a flag-register write, which exercises the rule that the set wins.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
   localparam int WORD_W   = 32;
   localparam int MB_WORDS = 4;
   localparam int STD_ID_W = 11;
   localparam int ID_LSB   = 18;
   localparam int CODE_LSB = 24;
   localparam int CODE_W   = 3;
   localparam int DLC_LSB  = 16;
   localparam int DLC_W    = 4;
   localparam int DATA_W   = 64;

   localparam logic [CODE_W-1:0] CODE_ARMED = 3'd4;
   localparam logic [CODE_W-1:0] CODE_FULL  = 3'd2;

   typedef enum logic [1:0] {
      W_CS  = 2'd0,
      W_ID  = 2'd1,
      W_DHI = 2'd2,
      W_DLO = 2'd3
   } mb_word_e;

   typedef struct packed {
      logic self_drop;
      logic indiv_en;
   } ctrl_t;

   function automatic logic [WORD_W-1:0] make_cs(input logic [DLC_W-1:0] dlc);
      logic [WORD_W-1:0] w;
      w = '0;
      w[CODE_LSB +: CODE_W] = CODE_FULL;
      w[DLC_LSB +: DLC_W]   = dlc;
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] make_id(input logic [STD_ID_W-1:0] id);
      logic [WORD_W-1:0] w;
      w = '0;
      w[ID_LSB +: STD_ID_W] = id;
      return w;
   endfunction
endpackage

// File: rtl/can_rx_id_match.sv
module can_rx_id_match
   import can_rx_pkg::*;
(
   input  logic [CODE_W-1:0]   code,
   input  logic [STD_ID_W-1:0] mb_id,
   input  logic [STD_ID_W-1:0] mask_id,
   input  logic [STD_ID_W-1:0] rx_id,
   output logic                hit
);
   logic [STD_ID_W-1:0] diff;

   always_comb begin
      diff = (rx_id ^ mb_id) & mask_id;
      hit  = (code == CODE_ARMED) && (diff == '0);
   end
endmodule

// File: rtl/can_rx_prio_pick.sv
module can_rx_prio_pick #(
   parameter  int N  = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   always_comb begin
      any   = |req;
      grant = req & (~req + N'(1));
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/can_rx_acceptance.sv
module can_rx_acceptance
   import can_rx_pkg::*;
#(
   parameter  int NUM_MB     = 32,
   localparam int MB_IW      = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
   localparam int RAM_WORDS  = NUM_MB * MB_WORDS,
   localparam int MASK_BASE  = RAM_WORDS,
   localparam int GMASK_ADDR = MASK_BASE + NUM_MB,
   localparam int CTRL_ADDR  = GMASK_ADDR + 1,
   localparam int FLAG_ADDR  = GMASK_ADDR + 2,
   localparam int ADDR_W     = $clog2(FLAG_ADDR + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_valid,
   input  logic [STD_ID_W-1:0] rx_id,
   input  logic [DLC_W-1:0]    rx_dlc,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic                rx_self,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic [NUM_MB-1:0]   mb_flags
);
   localparam int RAM_AW = MB_IW + 2;

   generate
      if (NUM_MB < 1 || NUM_MB > WORD_W) begin : g_bad_count
         $error("NUM_MB must lie between 1 and the register width");
      end
   endgenerate

   // storage
   logic [WORD_W-1:0] ram_q   [RAM_WORDS];
   logic [WORD_W-1:0] imask_q [NUM_MB];
   logic [WORD_W-1:0] gmask_q;
   ctrl_t             ctrl_q;
   logic [NUM_MB-1:0] flags_q;
   logic              self_drop_q;

   assign self_drop_q = ctrl_q.self_drop;

   // address decode
   logic              sel_ram, sel_mask, sel_gmask, sel_ctrl, sel_flag;
   logic [RAM_AW-1:0] ram_idx;
   logic [MB_IW-1:0]  mask_idx;

   always_comb begin
      sel_ram   = reg_addr < ADDR_W'(RAM_WORDS);
      sel_mask  = !sel_ram && (reg_addr < ADDR_W'(GMASK_ADDR));
      sel_gmask = reg_addr == ADDR_W'(GMASK_ADDR);
      sel_ctrl  = reg_addr == ADDR_W'(CTRL_ADDR);
      sel_flag  = reg_addr == ADDR_W'(FLAG_ADDR);
      ram_idx   = reg_addr[RAM_AW-1:0];
      mask_idx  = MB_IW'(reg_addr - ADDR_W'(MASK_BASE));
   end

   // per-mailbox acceptance
   logic [NUM_MB-1:0] hit, grant;
   logic              any_hit;
   logic [MB_IW-1:0]  win_idx;

   generate
      for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
         logic [STD_ID_W-1:0] mask_sel;
         assign mask_sel = ctrl_q.indiv_en ? imask_q[g][ID_LSB +: STD_ID_W]
                                           : gmask_q[ID_LSB +: STD_ID_W];
         can_rx_id_match i_match (
            .code    (ram_q[g*MB_WORDS + int'(W_CS)][CODE_LSB +: CODE_W]),
            .mb_id   (ram_q[g*MB_WORDS + int'(W_ID)][ID_LSB +: STD_ID_W]),
            .mask_id (mask_sel),
            .rx_id   (rx_id),
            .hit     (hit[g])
         );
      end
   endgenerate

   can_rx_prio_pick #(.N(NUM_MB)) i_pick (
      .req   (hit),
      .any   (any_hit),
      .idx   (win_idx),
      .grant (grant)
   );

   logic              frame_ok, store_en;
   logic [RAM_AW-1:0] base;
   logic [NUM_MB-1:0] flags_nx;
   logic [WORD_W-1:0] rd_word;

   always_comb begin
      frame_ok = rx_valid && !(ctrl_q.self_drop && rx_self);
      store_en = frame_ok && any_hit;
      base     = {win_idx, 2'b00};

      flags_nx = flags_q;
      if (reg_wr && sel_flag) flags_nx = flags_nx & ~reg_wdata[NUM_MB-1:0];
      if (store_en)           flags_nx = flags_nx | grant;

      if (sel_ram)        rd_word = ram_q[ram_idx];
      else if (sel_mask)  rd_word = imask_q[mask_idx];
      else if (sel_gmask) rd_word = gmask_q;
      else if (sel_ctrl)  rd_word = WORD_W'(ctrl_q);
      else if (sel_flag)  rd_word = WORD_W'(flags_q);
      else                rd_word = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_WORDS; i++) ram_q[i] <= '0;
         for (int i = 0; i < NUM_MB; i++)    imask_q[i] <= '0;
         gmask_q   <= '0;
         ctrl_q    <= '0;
         flags_q   <= '0;
         reg_rdata <= '0;
      end else begin
         reg_rdata <= rd_word;
         if (reg_wr) begin
            if (sel_ram)   ram_q[ram_idx]     <= reg_wdata;
            if (sel_mask)  imask_q[mask_idx]  <= reg_wdata;
            if (sel_gmask) gmask_q            <= reg_wdata;
            if (sel_ctrl)  ctrl_q             <= ctrl_t'(reg_wdata[1:0]);
         end
         if (store_en) begin
            ram_q[base | RAM_AW'(W_CS)]  <= make_cs(rx_dlc);
            ram_q[base | RAM_AW'(W_ID)]  <= make_id(rx_id);
            ram_q[base | RAM_AW'(W_DHI)] <= rx_data[DATA_W-1:WORD_W];
            ram_q[base | RAM_AW'(W_DLO)] <= rx_data[WORD_W-1:0];
         end
         flags_q <= flags_nx;
      end
   end

   assign mb_flags = flags_q;
endmodule

// File: rtl/can_rx_acceptance_chk.sv
module can_rx_acceptance_chk #(
   parameter int NUM_MB    = 32,
   parameter int ADDR_W    = 8,
   parameter int FLAG_ADDR = 162
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_self,
   input logic              self_drop,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [NUM_MB-1:0] wr_bits,
   input logic [NUM_MB-1:0] mb_flags
);
   // R1: flags held clear while in reset
   always @(negedge clk) begin
      if (!rst_n) a_r1_flags_clear: assert (mb_flags == '0);
   end

   // R10: without a frame no flag can rise
   a_r10_no_frame_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> ((mb_flags & ~$past(mb_flags)) == '0));

   // R5: a frame sets at most one flag
   a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> $onehot0(mb_flags & ~$past(mb_flags)));

   // R11: a dropped self-sent frame sets nothing
   a_r11_self_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_self && self_drop) |=> ((mb_flags & ~$past(mb_flags)) == '0));

   // R9: write-one-to-clear on the flag register
   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(FLAG_ADDR) && !rx_valid)
         |=> (mb_flags == ($past(mb_flags) & ~$past(wr_bits))));
endmodule

bind can_rx_acceptance can_rx_acceptance_chk #(
   .NUM_MB    (NUM_MB),
   .ADDR_W    (ADDR_W),
   .FLAG_ADDR (FLAG_ADDR)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_self   (rx_self),
   .self_drop (self_drop_q),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .wr_bits   (reg_wdata[NUM_MB-1:0]),
   .mb_flags  (mb_flags)
);

// File: tb/test_can_rx_acceptance.sv
module test_can_rx_acceptance;
   localparam int A_IM = 128;
   localparam int A_GM = 160;
   localparam int A_CT = 161;
   localparam int A_FL = 162;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [10:0] rx_id = '0;
   logic [3:0]  rx_dlc = '0;
   logic [63:0] rx_data = '0;
   logic        rx_self = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] mb_flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   can_rx_acceptance i_can_rx_acceptance (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
      .rx_dlc(rx_dlc), .rx_data(rx_data), .rx_self(rx_self),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mb_flags(mb_flags)
   );

   // behavioural reference model
   logic [31:0] m_ram   [0:127];
   logic [31:0] m_imask [0:31];
   logic [31:0] m_gmask, m_ctrl, m_flags, m_rdata;

   function automatic logic [31:0] m_read(input int a);
      if (a < 128)       return m_ram[a];
      else if (a < A_GM) return m_imask[a-A_IM];
      else if (a == A_GM) return m_gmask;
      else if (a == A_CT) return m_ctrl;
      else if (a == A_FL) return m_flags;
      return 32'd0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) m_ram[i] = '0;
         for (int i = 0; i < 32; i++)  m_imask[i] = '0;
         m_gmask = '0; m_ctrl = '0; m_flags = '0; m_rdata = '0;
      end else begin
         int win;
         int a;
         logic [31:0] mk;
         a = int'(reg_addr);
         m_rdata = m_read(a);
         win = -1;
         if (rx_valid && !(m_ctrl[1] && rx_self)) begin
            for (int i = 0; i < 32; i++) begin
               mk = m_ctrl[0] ? m_imask[i] : m_gmask;
               if (win < 0 && m_ram[4*i][26:24] == 3'd4 &&
                   ((rx_id ^ m_ram[4*i+1][28:18]) & mk[28:18]) == 11'd0)
                  win = i;
            end
         end
         if (reg_wr) begin
            if (a < 128)        m_ram[a] = reg_wdata;
            else if (a < A_GM)  m_imask[a-A_IM] = reg_wdata;
            else if (a == A_GM) m_gmask = reg_wdata;
            else if (a == A_CT) m_ctrl = {30'd0, reg_wdata[1:0]};
            else if (a == A_FL) m_flags = m_flags & ~reg_wdata;
         end
         if (win >= 0) begin
            m_ram[4*win]   = {5'd0, 3'd2, 4'd0, rx_dlc, 16'd0};
            m_ram[4*win+1] = {3'd0, rx_id, 18'd0};
            m_ram[4*win+2] = rx_data[63:32];
            m_ram[4*win+3] = rx_data[31:0];
            m_flags[win]   = 1'b1;
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks += 2;
         if (mb_flags !== m_flags) begin
            errors++;
            $display("FAIL R8 flags act %h exp %h", mb_flags, m_flags);
         end
         if (reg_rdata !== m_rdata) begin
            errors++;
            $display("FAIL R2 read data act %h exp %h", reg_rdata, m_rdata);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_addr = 8'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rchk(input string tag, input int a, input logic [31:0] exp);
      reg_addr = 8'(a);
      @(negedge clk);
      chk(tag, reg_rdata, exp);
   endtask

   task automatic frm(input logic [10:0] id, input logic [3:0] dlc,
                      input logic [63:0] dat, input logic self);
      rx_id = id; rx_dlc = dlc; rx_data = dat; rx_self = self; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_self = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 flags port", mb_flags, 32'h0);
      rchk("R1 mode reg", A_CT, 32'h0);
      rchk("R1 mailbox word", 17, 32'h0);
      rchk("R1 shared mask", A_GM, 32'h0);

      // R2 register access
      wr(17, 32'h0800_0000);
      rchk("R2 id word", 17, 32'h0800_0000);
      wr(132, 32'h0FC0_0000);
      rchk("R2 own mask", 132, 32'h0FC0_0000);
      wr(A_CT, 32'h3);
      rchk("R2 mode bits", A_CT, 32'h3);
      wr(A_CT, 32'h0);

      // R3 shared mask zero accepts anything; R6 stored contents
      wr(16, 32'h0400_0000);
      frm(11'h101, 4'd8, 64'h1122_3344_5566_7788, 1'b0);
      chk("R8 flag after store", mb_flags, 32'h10);
      rchk("R6 status word", 16, 32'h0208_0000);
      rchk("R6 id word", 17, 32'h0404_0000);
      rchk("R6 data hi", 18, 32'h1122_3344);
      rchk("R6 data lo", 19, 32'h5566_7788);

      // R7 full mailbox refuses, R10 no state change
      frm(11'h102, 4'd3, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
      chk("R7 flags unchanged", mb_flags, 32'h10);
      rchk("R10 id kept", 17, 32'h0404_0000);
      rchk("R7 status kept", 16, 32'h0208_0000);
      wr(A_FL, 32'h10);
      chk("R9 flag cleared", mb_flags, 32'h0);

      // R4 individual masks: range and exact
      wr(A_CT, 32'h1);
      wr(16, 32'h0400_0000);
      wr(17, 32'h0800_0000);
      wr(132, 32'h0FC0_0000);
      wr(12, 32'h0400_0000);
      wr(13, 32'h0840_0000);
      wr(131, 32'h0FFC_0000);
      frm(11'h211, 4'd2, 64'h1, 1'b0);
      chk("R4 0x211 rejected", mb_flags, 32'h0);
      frm(11'h20F, 4'd1, 64'h2, 1'b0);
      chk("R4 range hit", mb_flags, 32'h10);
      rchk("R4 stored id", 17, 32'h083C_0000);
      frm(11'h210, 4'd5, 64'h3, 1'b0);
      chk("R4 exact hit", mb_flags, 32'h18);
      rchk("R6 dlc five", 12, 32'h0205_0000);
      wr(A_FL, 32'h08);
      chk("R9 only written bit", mb_flags, 32'h10);
      wr(A_FL, 32'h10);
      chk("R9 all clear", mb_flags, 32'h0);

      // R5 lowest mailbox wins
      wr(A_CT, 32'h0);
      wr(8, 32'h0400_0000);
      wr(24, 32'h0400_0000);
      frm(11'h7FF, 4'd0, 64'h4, 1'b0);
      chk("R5 lowest wins", mb_flags, 32'h04);
      rchk("R5 loser still armed", 24, 32'h0400_0000);

      // R11 self-sent frames
      wr(A_CT, 32'h2);
      frm(11'h055, 4'd4, 64'h5, 1'b1);
      chk("R11 self frame dropped", mb_flags, 32'h04);
      rchk("R11 mailbox untouched", 24, 32'h0400_0000);
      frm(11'h056, 4'd4, 64'h6, 1'b0);
      chk("R11 foreign frame taken", mb_flags, 32'h44);
      wr(A_CT, 32'h0);
      wr(24, 32'h0400_0000);
      frm(11'h057, 4'd4, 64'h7, 1'b1);
      rchk("R11 self frame taken when enabled", 25, 32'h015C_0000);
      wr(A_FL, 32'hFFFF_FFFF);
      chk("R9 clear all", mb_flags, 32'h0);

      // R9 set wins over clear in the same cycle
      wr(28, 32'h0400_0000);
      reg_addr = 8'(A_FL); reg_wdata = 32'h80; reg_wr = 1'b1;
      rx_id = 11'h333; rx_dlc = 4'd2; rx_data = 64'h8; rx_valid = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; rx_valid = 1'b0;
      chk("R9 set beats clear", mb_flags, 32'h80);

      // R3 nonzero shared mask
      wr(A_FL, 32'hFFFF_FFFF);
      wr(A_GM, 32'h1FFC_0000);
      wr(32, 32'h0400_0000);
      wr(33, 32'h048C_0000);
      frm(11'h124, 4'd1, 64'h9, 1'b0);
      chk("R3 mismatch rejected", mb_flags, 32'h0);
      frm(11'h123, 4'd1, 64'hA, 1'b0);
      chk("R3 exact accepted", mb_flags, 32'h100);

      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule